// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between an on-chip valid/ready request port and an external asynchronous static RAM of 128K locations by 16 bits. Each accepted request is a word or single-byte read or write. The block turns it into a sequence of active-low strobes: chip select, write enable, output enable, and one select for each of the two byte lanes. The strobes are timed by counting clock cycles. The shared bidirectional data bus appears as three separate signals: data out, data in, and a drive enable for the controller's bus drivers.

Every timing minimum is a nanosecond parameter. The block converts it to a whole number of clock cycles by rounding up. With the default 8 ns clock the counts are as follows:
- The output-enable window of a read is 9 cycles.
- The write-enable pulse is 7 cycles.
- The bus turnaround after a read is 4 cycles.

Read data is captured on the clock edge that closes the output-enable window. Each request completes with a one-cycle response pulse. A request whose byte mask is empty completes at once and touches no strobe.

Top module: `sram_lane_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, every active-low strobe is high, the data drive enable is low, and no response is signalled; the request port shows ready after reset.
- R2: Mask bit 0 selects the lower lane (data bits 7:0, lower select low) and mask bit 1 selects the upper lane (bits 15:8, upper select low); a write changes only the selected lanes, and on a read the bytes of unselected lanes are returned as zero.
- R3: A read drives chip select and the lane selects low for one setup cycle, then holds output enable low for 9 cycles with write enable high; the response pulse appears 11 cycles after the accepting edge carrying the data present at the end of the window.
- R4: A write drives the data and the drive enable from the setup cycle through one hold cycle after the strobe, holds write enable low for 7 cycles with output enable high, and signals its response 10 cycles after the accepting edge with zero data.
- R5: The address outputs change only on edges where write enable is high before and after the edge.
- R6: The drive enable is never high while output enable is low, and after output enable rises it stays low for at least 4 cycles.
- R7: A request with mask 00 asserts no strobe and signals its response in the cycle right after acceptance with zero data.
- R8: Ready is high only when no access is in progress; it is low whenever chip select is low.
- R9: Write enable is low only while chip select is low, at least one lane select is low, and the controller drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 17 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes (bit 0 lower, bit 1 upper) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, zero for writes and empty masks |
| mem_addr | output | 17 | RAM address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_in | input | 16 | Data from the RAM |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
Response timing is checked against the accepting edge. A read's pulse is due 11 cycles later, a write's 10 cycles later, and an empty-mask request's 1 cycle later. The driver records the edge count when it offers a request and queues the expected data together with that due count. The monitor samples on falling edges and compares both the data and the edge on which the pulse arrives. The RAM model presents valid data only in the final cycle of a full output-enable window, so a capture one cycle early returns a wrong pattern. Pulse widths and the read-to-drive gap are measured from the pins on every access.

// File: rtl/sram_lane_ctl_pkg.sv
package sram_lane_ctl_pkg;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 2;
    localparam int unsigned DATA_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic lb_n;
        logic ub_n;
        logic dq_oe;
    } pin_set_t;

    localparam pin_set_t PINS_QUIET = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                        lb_n: 1'b1, ub_n: 1'b1, dq_oe: 1'b0};

    // Round a nanosecond minimum up to whole clock periods, never below one.
    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Pin levels for the cycle spent in a given state.
    function automatic pin_set_t pins_for(ctl_state_e st, logic wr, logic [LANES-1:0] lanes);
        pin_set_t p;
        p = PINS_QUIET;
        if (st == ST_SETUP || st == ST_STROBE || st == ST_HOLD) begin
            p.cs_n  = 1'b0;
            p.lb_n  = ~lanes[0];
            p.ub_n  = ~lanes[1];
            p.dq_oe = wr;
            if (st == ST_STROBE) begin
                if (wr) p.we_n = 1'b0;
                else    p.oe_n = 1'b0;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/sram_lane_ctl_timer.sv
module sram_lane_ctl_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_ctl_merge.sv
module sram_lane_ctl_merge
    import sram_lane_ctl_pkg::*;
(
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = lane_en[g] ? raw[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_lane_ctl.sv
module sram_lane_ctl
    import sram_lane_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_READ_NS = 70,
    parameter int unsigned T_WEN_NS  = 55,
    parameter int unsigned T_REL_NS  = 25
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [LANES-1:0]   req_mask,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_cs_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic               mem_lb_n,
    output logic               mem_ub_n,
    output logic [DATA_W-1:0]  mem_dq_out,
    input  logic [DATA_W-1:0]  mem_dq_in,
    output logic               mem_dq_oe
);
    localparam int unsigned SETUP_CYC = 1;
    localparam int unsigned HOLD_CYC  = 1;
    localparam int unsigned RD_CYC    = ns_to_cycles(T_READ_NS, CLK_NS);
    localparam int unsigned WP_CYC    = ns_to_cycles(T_WEN_NS, CLK_NS);
    localparam int unsigned TA_CYC    = ns_to_cycles(T_REL_NS, CLK_NS);
    localparam int unsigned MAX_CYC   = max3(RD_CYC, WP_CYC, TA_CYC);
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    ctl_state_e         state_q, state_d;
    logic               wr_q, wr_d;
    logic [LANES-1:0]   mask_q, mask_d;
    pin_set_t           pins_q;
    logic               accept, rsp_set, capture;
    logic               t_load, t_done;
    logic [CNT_W-1:0]   t_val;
    logic [DATA_W-1:0]  rd_merged;

    sram_lane_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_lane_ctl_merge u_merge (
        .lane_en (mask_q),
        .raw     (mem_dq_in),
        .merged  (rd_merged)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_d      = accept ? req_write : wr_q;
    assign mask_d    = accept ? req_mask  : mask_q;

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        rsp_set = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_mask == '0) begin
                        rsp_set = 1'b1;
                    end else begin
                        state_d = ST_SETUP;
                        t_load  = 1'b1;
                        t_val   = CNT_W'(SETUP_CYC - 1);
                    end
                end
            end
            ST_SETUP: begin
                if (t_done) begin
                    state_d = ST_STROBE;
                    t_load  = 1'b1;
                    t_val   = wr_q ? CNT_W'(WP_CYC - 1) : CNT_W'(RD_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (wr_q) begin
                        state_d = ST_HOLD;
                        t_val   = CNT_W'(HOLD_CYC - 1);
                    end else begin
                        state_d = ST_TURN;
                        t_val   = CNT_W'(TA_CYC - 1);
                        capture = 1'b1;
                        rsp_set = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (t_done) begin
                    state_d = ST_IDLE;
                    rsp_set = 1'b1;
                end
            end
            ST_TURN: begin
                if (t_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            wr_q       <= 1'b0;
            mask_q     <= '0;
            pins_q     <= PINS_QUIET;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else begin
            state_q   <= state_d;
            wr_q      <= wr_d;
            mask_q    <= mask_d;
            pins_q    <= pins_for(state_d, wr_d, mask_d);
            rsp_valid <= rsp_set;
            if (capture)      rsp_rdata <= rd_merged;
            else if (rsp_set) rsp_rdata <= '0;
            if (accept && req_mask != '0) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
        end
    end

    assign mem_cs_n  = pins_q.cs_n;
    assign mem_we_n  = pins_q.we_n;
    assign mem_oe_n  = pins_q.oe_n;
    assign mem_lb_n  = pins_q.lb_n;
    assign mem_ub_n  = pins_q.ub_n;
    assign mem_dq_oe = pins_q.dq_oe;
endmodule

// File: rtl/sram_lane_ctl_chk.sv
module sram_lane_ctl_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned RD_CYC = 9,
    parameter int unsigned WP_CYC = 7,
    parameter int unsigned TA_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_dq_oe
);
    logic [7:0] we_run, oe_run, oe_quiet;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run   <= '0;
            oe_run   <= '0;
            oe_quiet <= 8'hFF;
        end else begin
            we_run   <= !mem_we_n ? ((we_run == 8'hFF) ? we_run : we_run + 1'b1) : '0;
            oe_run   <= !mem_oe_n ? ((oe_run == 8'hFF) ? oe_run : oe_run + 1'b1) : '0;
            oe_quiet <= !mem_oe_n ? '0 : ((oe_quiet == 8'hFF) ? oe_quiet : oe_quiet + 1'b1);
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n
                        && !mem_dq_oe && !rsp_valid));

    p_read_we_high_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n));

    p_oe_window_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> ({24'd0, oe_run} >= RD_CYC));

    p_we_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> ({24'd0, we_run} >= WP_CYC));

    p_addr_move_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

    p_no_fight_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> ({24'd0, oe_quiet} >= TA_CYC));

    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready);

    p_write_window_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && !(mem_lb_n && mem_ub_n) && mem_dq_oe));
endmodule

bind sram_lane_ctl sram_lane_ctl_chk #(
    .ADDR_W (ADDR_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctl_test.sv
module sram_lane_ctl_test;
    localparam int RD = 9;
    localparam int WP = 7;
    localparam int TA = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    always #4 clk = ~clk;

    sram_lane_ctl uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit done   = 1'b0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural RAM with lane-masked storage
    logic [15:0] ram [logic [16:0]];
    logic [7:0]  oe_low_cnt = '0;

    always @(posedge clk) begin
        edges <= edges + 1;
        oe_low_cnt <= !mem_oe_n ? oe_low_cnt + 1'b1 : '0;
        if (!mem_cs_n && !mem_we_n) begin
            logic [15:0] cur;
            cur = ram.exists(mem_addr) ? ram[mem_addr] : 16'h0000;
            if (!mem_lb_n) cur[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) cur[15:8] = mem_dq_out[15:8];
            ram[mem_addr] = cur;
        end
    end

    // Data becomes valid only in the final cycle of a full OE window.
    always_comb begin
        logic [15:0] st;
        st = ram.exists(mem_addr) ? ram[mem_addr] : 16'h0000;
        if (!mem_cs_n && !mem_oe_n && mem_we_n && oe_low_cnt >= 8'(RD - 1))
            mem_dq_in = {mem_ub_n ? 8'hEE : st[15:8], mem_lb_n ? 8'hEE : st[7:0]};
        else
            mem_dq_in = 16'hBAD0;
    end

    // ---------------- scoreboard
    typedef struct {
        logic [15:0] data;
        int          due;
        string       tag;
    } exp_t;
    exp_t        sb[$];
    logic [15:0] shadow [logic [16:0]];

    task automatic send(logic [16:0] a, logic w, logic [15:0] d, logic [1:0] m, string tag);
        exp_t e;
        logic [15:0] cur;
        int lat;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; req_mask = m;
        cur = shadow.exists(a) ? shadow[a] : 16'h0000;
        if (m == 2'b00)  lat = 1;
        else if (w)      lat = 1 + 1 + WP + 1;
        else             lat = 1 + 1 + RD;
        e.due  = edges + lat;
        e.tag  = tag;
        e.data = 16'h0000;
        if (w) begin
            if (m[0]) cur[7:0]  = d[7:0];
            if (m[1]) cur[15:8] = d[15:8];
            shadow[a] = cur;
        end else begin
            e.data = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
        end
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // ---------------- monitor: responses and pin timing
    int we_len = 0, oe_len = 0, oe_gap = 1000;
    logic dq_prev = 1'b0;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (rsp_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R3 unexpected response", {16'h0, rsp_rdata}, 32'h0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(rsp_rdata == e.data, {e.tag, " data"}, {16'h0, rsp_rdata}, {16'h0, e.data});
                        check(edges == e.due, {e.tag, " latency"}, edges, e.due);
                    end
                end
                if (!mem_we_n) we_len++;
                else if (we_len > 0) begin
                    check(we_len >= WP, "R4 write pulse width", we_len, WP);
                    we_len = 0;
                end
                if (!mem_oe_n) oe_len++;
                else if (oe_len > 0) begin
                    check(oe_len >= RD, "R3 output enable window", oe_len, RD);
                    oe_len = 0;
                end
                if (!mem_oe_n && mem_dq_oe)
                    check(1'b0, "R6 drive during read", 1, 0);
                if (!mem_we_n && (mem_cs_n || (mem_lb_n && mem_ub_n) || !mem_dq_oe || !mem_oe_n))
                    check(1'b0, "R9 write window", 1, 0);
                if (!mem_cs_n && req_ready)
                    check(1'b0, "R8 ready while busy", 1, 0);
                if (mem_dq_oe && !dq_prev)
                    check(oe_gap > TA, "R6 turnaround gap", oe_gap, TA + 1);
                oe_gap  = !mem_oe_n ? 0 : oe_gap + 1;
                dq_prev = mem_dq_oe;
            end
        end
    end

    // ---------------- watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus
    initial begin
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rsp_valid,
              "R1 pins in reset", {26'h0, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
              32'h3E);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && mem_cs_n && !mem_dq_oe && !rsp_valid, "R1 idle after reset",
              {29'h0, req_ready, mem_cs_n, mem_dq_oe}, 32'h6);

        send(17'h00010, 1'b1, 16'hA5C3, 2'b11, "R4 word write");
        send(17'h00010, 1'b0, 16'h0000, 2'b11, "R3 word read");
        send(17'h00010, 1'b1, 16'h7711, 2'b10, "R2 upper write");
        send(17'h00010, 1'b0, 16'h0000, 2'b11, "R2 word after upper write");
        send(17'h00010, 1'b0, 16'h0000, 2'b01, "R2 lower read");
        send(17'h00010, 1'b0, 16'h0000, 2'b10, "R2 upper read");
        send(17'h1FFFF, 1'b1, 16'h1234, 2'b01, "R2 lower write top address");
        send(17'h1FFFF, 1'b0, 16'h0000, 2'b11, "R2 read top address");

        send(17'h00010, 1'b1, 16'hFFFF, 2'b00, "R7 empty write");
        check(mem_cs_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe, "R7 no strobe",
              {28'h0, mem_cs_n, mem_we_n, mem_lb_n, mem_ub_n}, 32'hF);
        send(17'h00010, 1'b0, 16'h0000, 2'b00, "R7 empty read");
        send(17'h00010, 1'b0, 16'h0000, 2'b11, "R7 contents unchanged");

        for (int i = 0; i < 8; i++) begin
            logic [16:0] a;
            a = 17'((i * 4099 + 5) & 17'h1FFFF);
            send(a, 1'b1, 16'((i * 16'h1357) ^ 16'hA0A0), 2'(i % 3 + 1), "R5 pattern write");
            send(a, 1'b0, 16'h0000, 2'b11, "R5 pattern read");
        end
        send(17'h0ABCD, 1'b0, 16'h0000, 2'b11, "R3 unwritten read");

        while (sb.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule